// File: doc/BRIEF.md
# Card Socket Address Window Decoder

This block sits between a host bus and a pair of card slots. It checks every host access against eight programmable windows. Each window has a base register and an option register. The option register enables the window, can block writes, tags the window with an address space (common memory, attribute memory or I/O), selects one of the two slots, selects an 8-bit or 16-bit card port, and sets the window size through a 5-bit code.

For each access the decoder picks the lowest-numbered window that claims the address. One cycle later it reports the window index, the slot, the space tag, the port width and the offset into card space. A write that lands in a write-protected window is not forwarded. Instead the block raises a one-cycle protection error. An access that no window claims raises a one-cycle miss flag. Software programs and reads back the window registers through a small synchronous register port.

Top module: `cwd_window_decoder`

## Requirements
- R1: After reset every window is disabled and every register reads zero. An access therefore produces a miss and never a hit.
- R2: The register address is `{window index, select}`. A select of 0 picks the base register and 1 picks the option register. Read data appears one cycle after the address is presented. Option fields read back in place: bit 0 enable, bit 1 write protect, bit 2 slot, bits 4:3 space, bit 6 wide port and bits 31:27 size code. All other option bits read as zero.
- R3: Size code to window size in bytes:
  - 0→1, 1→2, 2→8, 3→4
  - 4→128, 5→64, 6→16, 7→32
  - 8→32768, 9→16384, 10→4096, 11→8192
  - 12→256, 13→512, 14→2048, 15→1024
  - 20→16M, 21→32M, 23→64M
  - 24→64K, 25→128K, 26→512K, 27→256K
  - 28→8M, 29→4M, 30→1M, 31→2M
- R4: A window claims an address when it is enabled and (address − base) modulo 2^32 is below its size. When several windows claim an address, the lowest index wins.
- R5: One cycle after an accepted access, the hit flag is high together with the window index, the slot, the space code, the wide flag and the offset (address − effective base).
- R6: In memory windows (space code other than 11), base bits 11:0 are ignored and taken as zero.
- R7: An I/O window (space 11) whose size is larger than 64 KB never claims an address.
- R8: A write that the winning window write-protects gives no hit. It gives a one-cycle protection error instead. Reads of that window hit normally.
- R9: An access that no window claims gives a one-cycle miss flag.
- R10: Writing zero to an option register disables that window for every access presented after that write.
- R11: Size codes 16 to 19 and 22 are invalid, and a window that holds one never claims an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address {window, select} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle latency |
| acc_valid | input | 1 | Host access present |
| acc_write | input | 1 | Host access is a write |
| acc_addr | input | 32 | Host address |
| out_hit | output | 1 | Access forwarded to a window |
| out_miss | output | 1 | No window claimed the access |
| out_prot_err | output | 1 | Write to a protected window |
| out_win | output | 3 | Winning window index |
| out_slot | output | 1 | Slot driven by the winning window |
| out_space | output | 2 | Space code of the winning window |
| out_wide | output | 1 | 16-bit port selected |
| out_offset | output | 32 | Card-side offset |

## Verification
The assertions assume that `acc_valid` and `acc_write` are defined on every clock edge once reset is released. They also assume that register writes and host accesses may overlap only in the sense that an access sees the register contents from before a write on the same edge. The stimulus drives every input on the falling clock edge and holds `acc_valid` low between accesses. Each reprogramming write completes at least one cycle before the access that depends on it. Windows are deliberately placed so that two of them overlap, some accesses land exactly on size boundaries, and some addresses fall below a base, so that the subtraction wraps around.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  typedef enum logic [1:0] {
    SP_COMMON = 2'b00,
    SP_RSVD   = 2'b01,
    SP_ATTR   = 2'b10,
    SP_IO     = 2'b11
  } space_e;

  typedef struct packed {
    logic [4:0] size_code;
    logic       wide;
    space_e     space;
    logic       slot;
    logic       wprot;
    logic       valid;
  } win_opt_t;

  typedef struct packed {
    logic       ok;
    logic [4:0] lg;
  } size_dec_t;

  // Gray-like size code to log2(bytes); unlisted codes are invalid
  function automatic size_dec_t decode_size(input logic [4:0] code);
    size_dec_t d;
    d.ok = 1'b1;
    d.lg = 5'd0;
    case (code)
      5'd0:  d.lg = 5'd0;
      5'd1:  d.lg = 5'd1;
      5'd2:  d.lg = 5'd3;
      5'd3:  d.lg = 5'd2;
      5'd4:  d.lg = 5'd7;
      5'd5:  d.lg = 5'd6;
      5'd6:  d.lg = 5'd4;
      5'd7:  d.lg = 5'd5;
      5'd8:  d.lg = 5'd15;
      5'd9:  d.lg = 5'd14;
      5'd10: d.lg = 5'd12;
      5'd11: d.lg = 5'd13;
      5'd12: d.lg = 5'd8;
      5'd13: d.lg = 5'd9;
      5'd14: d.lg = 5'd11;
      5'd15: d.lg = 5'd10;
      5'd20: d.lg = 5'd24;
      5'd21: d.lg = 5'd25;
      5'd23: d.lg = 5'd26;
      5'd24: d.lg = 5'd16;
      5'd25: d.lg = 5'd17;
      5'd26: d.lg = 5'd19;
      5'd27: d.lg = 5'd18;
      5'd28: d.lg = 5'd23;
      5'd29: d.lg = 5'd22;
      5'd30: d.lg = 5'd20;
      5'd31: d.lg = 5'd21;
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
  import cwd_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NWIN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W:0]      addr,
  input  logic [ADDR_W-1:0]   wdata,
  output logic [ADDR_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   base_q [NWIN],
  output win_opt_t            opt_q  [NWIN]
);

  localparam int PAD_W = ADDR_W - 12;

  logic [IDX_W-1:0] idx;
  logic             sel_opt;
  logic             unused_wdata;

  assign idx     = addr[IDX_W:1];
  assign sel_opt = addr[0];
  assign unused_wdata = ^{wdata[ADDR_W-6:7], wdata[5]};

  function automatic logic [ADDR_W-1:0] pack_opt(input win_opt_t o);
    return {o.size_code, {PAD_W{1'b0}}, o.wide, 1'b0, o.space,
            o.slot, o.wprot, o.valid};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        opt_q[i]  <= '0;
      end
    end else begin
      if (we) begin
        if (sel_opt) begin
          opt_q[idx].valid     <= wdata[0];
          opt_q[idx].wprot     <= wdata[1];
          opt_q[idx].slot      <= wdata[2];
          opt_q[idx].space     <= space_e'(wdata[4:3]);
          opt_q[idx].wide      <= wdata[6];
          opt_q[idx].size_code <= wdata[ADDR_W-1 -: 5];
        end else begin
          base_q[idx] <= wdata;
        end
      end
      rdata <= sel_opt ? pack_opt(opt_q[idx]) : base_q[idx];
    end
  end

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match
  import cwd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IO_MAX_LG = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              valid,
  input  logic              is_io,
  input  logic [4:0]        size_code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);

  size_dec_t         dec;
  logic [ADDR_W-1:0] eff_base;
  logic              io_too_big;

  always_comb begin
    dec        = decode_size(size_code);
    eff_base   = is_io ? base : {base[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    offset     = addr - eff_base;
    io_too_big = is_io && (dec.lg > 5'(IO_MAX_LG));
    hit        = valid && dec.ok && !io_too_big && ((offset >> dec.lg) == '0);
  end

endmodule

// File: rtl/cwd_prio.sv
module cwd_prio #(
  parameter int NWIN = 8,
  localparam int IDX_W = $clog2(NWIN)
) (
  input  logic [NWIN-1:0]  req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/cwd_window_decoder.sv
module cwd_window_decoder
  import cwd_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W:0]    cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              out_hit,
  output logic              out_miss,
  output logic              out_prot_err,
  output logic [IDX_W-1:0]  out_win,
  output logic              out_slot,
  output logic [1:0]        out_space,
  output logic              out_wide,
  output logic [ADDR_W-1:0] out_offset
);

  logic [ADDR_W-1:0] base_q [NWIN];
  win_opt_t          opt_q  [NWIN];
  logic [NWIN-1:0]   hit_vec;
  logic [ADDR_W-1:0] offs   [NWIN];
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  logic              blocked;

  cwd_regfile #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .base_q (base_q),
    .opt_q  (opt_q)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    cwd_win_match #(.ADDR_W(ADDR_W)) u_match (
      .base      (base_q[g]),
      .valid     (opt_q[g].valid),
      .is_io     (opt_q[g].space == SP_IO),
      .size_code (opt_q[g].size_code),
      .addr      (acc_addr),
      .hit       (hit_vec[g]),
      .offset    (offs[g])
    );
  end

  cwd_prio #(.NWIN(NWIN)) u_prio (
    .req (hit_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  assign blocked = acc_write && opt_q[win_idx].wprot;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hit      <= 1'b0;
      out_miss     <= 1'b0;
      out_prot_err <= 1'b0;
      out_win      <= '0;
      out_slot     <= 1'b0;
      out_space    <= 2'b00;
      out_wide     <= 1'b0;
      out_offset   <= '0;
    end else begin
      out_hit      <= acc_valid && any_hit && !blocked;
      out_prot_err <= acc_valid && any_hit && blocked;
      out_miss     <= acc_valid && !any_hit;
      if (acc_valid && any_hit) begin
        out_win    <= win_idx;
        out_slot   <= opt_q[win_idx].slot;
        out_space  <= opt_q[win_idx].space;
        out_wide   <= opt_q[win_idx].wide;
        out_offset <= offs[win_idx];
      end
    end
  end

endmodule

// File: rtl/cwd_window_decoder_chk.sv
module cwd_window_decoder_chk #(
  parameter int NWIN   = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NWIN)
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              out_hit,
  input logic              out_miss,
  input logic              out_prot_err,
  input logic [IDX_W-1:0]  out_win,
  input logic [1:0]        out_space,
  input logic [ADDR_W-1:0] out_offset
);

  logic unused_win;
  assign unused_win = ^out_win;

  // R4: one access yields at most one outcome
  a_r4_single_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_hit, out_miss, out_prot_err}));

  // R5: no outcome without an access on the previous edge
  a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !(out_hit || out_miss || out_prot_err));

  // R8: protection error only follows a write
  a_r8_prot_after_write: assert property (@(posedge clk) disable iff (rst)
    out_prot_err |-> $past(acc_valid && acc_write));

  // R9: miss only follows an access
  a_r9_miss_after_access: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> $past(acc_valid));

  // R7: I/O hits stay inside 64 KB
  a_r7_io_offset_limit: assert property (@(posedge clk) disable iff (rst)
    (out_hit && out_space == 2'b11) |-> (out_offset < ADDR_W'(65536)));

endmodule

bind cwd_window_decoder cwd_window_decoder_chk #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .out_hit      (out_hit),
  .out_miss     (out_miss),
  .out_prot_err (out_prot_err),
  .out_win      (out_win),
  .out_space    (out_space),
  .out_offset   (out_offset)
);

// File: tb/cwd_window_decoder_tb.sv
module cwd_window_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        out_hit, out_miss, out_prot_err, out_slot, out_wide;
  logic [2:0]  out_win;
  logic [1:0]  out_space;
  logic [31:0] out_offset;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  cwd_window_decoder u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .out_hit(out_hit), .out_miss(out_miss), .out_prot_err(out_prot_err),
    .out_win(out_win), .out_slot(out_slot), .out_space(out_space),
    .out_wide(out_wide), .out_offset(out_offset)
  );

  typedef struct {
    int          kind;   // 0 hit, 1 miss, 2 protect error
    logic [2:0]  win;
    logic        slot;
    logic [1:0]  space;
    logic        wide;
    logic [31:0] offset;
    string       tag;
  } exp_t;

  exp_t        sb_q [$];
  logic [31:0] m_base [8];
  logic [31:0] m_opt  [8];

  function automatic longint unsigned sz_bytes(input logic [4:0] c);
    case (c)
      0: return 1;        1: return 2;        2: return 8;        3: return 4;
      4: return 128;      5: return 64;       6: return 16;       7: return 32;
      8: return 32768;    9: return 16384;    10: return 4096;    11: return 8192;
      12: return 256;     13: return 512;     14: return 2048;    15: return 1024;
      20: return 64'h1000000; 21: return 64'h2000000; 23: return 64'h4000000;
      24: return 65536;   25: return 131072;  26: return 524288;  27: return 262144;
      28: return 64'h800000; 29: return 64'h400000; 30: return 64'h100000;
      31: return 64'h200000;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mk_opt(input logic v, input logic wp, input logic sl,
                                         input logic [1:0] sp, input logic wd,
                                         input logic [4:0] code);
    return {code, 20'b0, wd, 1'b0, sp, sl, wp, v};
  endfunction

  function automatic exp_t predict(input logic [31:0] a, input logic wr, input string tag);
    exp_t e;
    e.kind = 1; e.win = '0; e.slot = 0; e.space = '0; e.wide = 0; e.offset = '0;
    e.tag = tag;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] o, eb, d;
      longint unsigned sz;
      bit io;
      o  = m_opt[i];
      io = (o[4:3] == 2'b11);
      sz = sz_bytes(o[31:27]);
      eb = io ? m_base[i] : (m_base[i] & 32'hFFFF_F000);
      d  = a - eb;
      if (e.kind == 1 && o[0] && sz != 0 && !(io && sz > 65536) &&
          longint'(d) < longint'(sz)) begin
        e.kind   = (wr && o[1]) ? 2 : 0;
        e.win    = 3'(i);
        e.slot   = o[2];
        e.space  = o[4:3];
        e.wide   = o[6];
        e.offset = d;
      end
    end
    return e;
  endfunction

  task automatic fail_line(input string tag, input logic [63:0] act, input logic [63:0] exp);
    bad++;
    $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic wr_reg(input int w, input bit is_opt, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(w), is_opt}; cfg_wdata = d;
    if (is_opt) m_opt[w] = d; else m_base[w] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int w, input bit is_opt, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = {3'(w), is_opt};
    @(posedge clk); #1;
    total++;
    if (cfg_rdata !== exp) fail_line(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    sb_q.push_back(predict(a, wr, tag));
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst) begin
        total++;
        if (sb_q.size() == 0) begin
          if (out_hit || out_miss || out_prot_err)
            fail_line("R5 idle", 64'({out_hit, out_miss, out_prot_err}), 64'(0));
        end else begin
          exp_t e;
          logic [2:0] fl_exp;
          e = sb_q.pop_front();
          fl_exp = (e.kind == 0) ? 3'b100 : (e.kind == 1) ? 3'b010 : 3'b001;
          if ({out_hit, out_miss, out_prot_err} !== fl_exp)
            fail_line(e.tag, 64'({out_hit, out_miss, out_prot_err}), 64'(fl_exp));
          else if (e.kind == 0 &&
                   {out_win, out_slot, out_space, out_wide, out_offset} !==
                   {e.win, e.slot, e.space, e.wide, e.offset})
            fail_line(e.tag, {out_win, out_slot, out_space, out_wide, out_offset},
                      {e.win, e.slot, e.space, e.wide, e.offset});
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_opt[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_chk(7, 0, 32'h0, "R1 base reset");
    rd_chk(3, 1, 32'h0, "R1 option reset");
    access(32'h1000_0000, 0, "R1 miss after reset");

    // R2 field placement and readback
    wr_reg(6, 1, 32'hFFFF_FFFF);
    rd_chk(6, 1, 32'hF800_005F, "R2 option readback");
    wr_reg(6, 0, 32'h6000_0000);
    rd_chk(6, 0, 32'h6000_0000, "R2 base readback");

    // program windows
    wr_reg(0, 0, 32'h1000_0000); wr_reg(0, 1, mk_opt(1, 0, 0, 2'b00, 1, 5'd23));
    wr_reg(1, 0, 32'h1000_0000); wr_reg(1, 1, mk_opt(1, 0, 1, 2'b10, 0, 5'd20));
    wr_reg(2, 0, 32'h0000_0300); wr_reg(2, 1, mk_opt(1, 1, 1, 2'b11, 1, 5'd5));
    wr_reg(3, 0, 32'h2000_0ABC); wr_reg(3, 1, mk_opt(1, 0, 0, 2'b00, 0, 5'd25));
    wr_reg(4, 0, 32'h4000_0000); wr_reg(4, 1, mk_opt(1, 0, 0, 2'b11, 0, 5'd24));
    wr_reg(5, 0, 32'h5000_0000); wr_reg(5, 1, mk_opt(1, 0, 1, 2'b11, 0, 5'd25));
    wr_reg(6, 1, mk_opt(1, 0, 0, 2'b00, 0, 5'd22));
    wr_reg(7, 0, 32'h7000_0000); wr_reg(7, 1, mk_opt(1, 0, 1, 2'b10, 1, 5'd2));
    rd_chk(2, 1, 32'h2800_005F, "R2 option W2 readback");

    access(32'h1000_0100, 0, "R4 lowest index wins");
    access(32'h1000_0100, 1, "R5 write to open window");
    access(32'h0000_033F, 0, "R5 io hit last byte");
    access(32'h0000_0340, 0, "R4 io past end");
    access(32'h0000_0310, 1, "R8 protected write");
    access(32'h0000_0300, 0, "R8 protected read hits");
    access(32'h2000_0010, 0, "R6 base low bits ignored");
    access(32'h2002_0000, 0, "R9 memory past end");
    access(32'h4000_FFFF, 0, "R7 io 64K hit");
    access(32'h4001_0000, 0, "R7 io 64K end");
    access(32'h5000_0000, 0, "R7 io over 64K");
    access(32'h6000_0000, 0, "R11 code 22");
    wr_reg(6, 1, mk_opt(1, 0, 0, 2'b00, 0, 5'd16));
    access(32'h6000_0000, 0, "R11 code 16");
    access(32'h7000_0007, 0, "R3 code 2 last");
    access(32'h7000_0008, 0, "R3 code 2 end");
    access(32'h6FFF_FFFF, 0, "R4 below base");
    wr_reg(7, 1, mk_opt(1, 0, 1, 2'b10, 1, 5'd3));
    access(32'h7000_0003, 0, "R3 code 3 last");
    access(32'h7000_0004, 0, "R3 code 3 end");
    wr_reg(7, 1, mk_opt(1, 0, 1, 2'b10, 1, 5'd0));
    access(32'h7000_0000, 0, "R3 code 0 hit");
    access(32'h7000_0001, 0, "R3 code 0 end");
    wr_reg(7, 1, mk_opt(1, 0, 1, 2'b10, 1, 5'd14));
    access(32'h7000_07FF, 0, "R3 code 14 last");
    access(32'h7000_0800, 0, "R3 code 14 end");

    // R10 disable by zero option
    wr_reg(0, 1, 32'h0);
    access(32'h1000_0100, 0, "R10 disabled falls to next");
    wr_reg(1, 1, 32'h0);
    access(32'h1000_0100, 0, "R10 all disabled miss");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule